// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address for 4 KB pages. It does so by reading a two-level page table held in physical memory. When a request arrives, the walker records the table base register. It reads the first-level entry, then the second-level (leaf) entry. It then joins the leaf frame number to the untranslated page offset.

A request fails with a page fault if either entry is invalid, or if the access breaks the leaf's rights: a write to a read-only page, or a user-mode access to a supervisor-only page. On success the walker sets the leaf's used bit, and on a write also its dirty bit. It stores the updated entry back to memory only when one of those bits changes.

The walker talks to memory through one read/write port. That port holds each request until the memory acknowledges it. The walker presents its result to the requester until the requester acknowledges it. A translation buffer in front of the walker would issue requests on its misses and refill from the result.

Top module: `pt_walk_unit`

## Requirements
- R1: The first memory access of a walk is a read of the level-one entry at address `base + va[31:22]*4`. Here `base` is the value of `ptbr_i` sampled in the cycle the request is accepted.
- R2: Entry format, 32 bits:
  - frame number in bits [31:12];
  - valid in bit 0;
  - writable in bit 1;
  - user-accessible in bit 2;
  - used in bit 3;
  - dirty in bit 4.

  After a valid level-one entry, the second access reads the leaf at `{l1_frame, 12'h000} + va[21:12]*4`.
- R3: On success, `rsp_paddr_o` equals `{leaf_frame, va[11:0]}`, and `rsp_cause_o` is 0.
- R4: An invalid level-one entry ends the walk after that single read, with cause 1. An invalid leaf ends it after two reads with cause 2, and nothing is written.
- R5: A permission violation ends the walk with cause 3 and no write. A violation is either of the following:
  - a write to a leaf with writable clear;
  - a user access to a leaf with user clear.
- R6: On success, the walker builds the updated leaf by setting used, and by also setting dirty when the access is a write. Any write-back goes to the same address the leaf was read from.
- R7: The updated leaf is written back only when it differs from the leaf that was read. Otherwise the walk finishes after two reads.
- R8: Each walk ends with exactly one of `rsp_done_o` or `rsp_fault_o` high. That signal, the address and the cause stay stable until `rsp_ack_i`, and in the cycle after the ack the walker is idle again.
- R9: `req_ready_o` is high only when idle with no result pending. A `req_valid_i` seen while busy is ignored. A change of `ptbr_i` while busy has no effect on the walk in flight.
- R10: While `mem_req_o` is high without `mem_ack_i`, the address, direction and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptbr_i | input | 32 | Physical base address of the level-one table |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request will be taken |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_write_i | input | 1 | Access is a write |
| req_user_i | input | 1 | Access is from user mode |
| mem_req_o | output | 1 | Memory access request, held until ack |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Physical byte address of the entry |
| mem_wdata_o | output | 32 | Updated leaf entry for write-back |
| mem_ack_i | input | 1 | Memory completes the access this cycle |
| mem_rdata_i | input | 32 | Read data, valid with ack |
| rsp_done_o | output | 1 | Translation succeeded, held until ack |
| rsp_fault_o | output | 1 | Page fault, held until ack |
| rsp_cause_o | output | 2 | 0 none, 1 level-one invalid, 2 leaf invalid, 3 rights |
| rsp_paddr_o | output | 32 | Translated physical address |
| rsp_ack_i | input | 1 | Requester consumes the result |

## Verification
Two functions can act in the same cycle. One is the rights check that decides the walk's outcome. The other is the used/dirty update that decides whether a third, write access follows. Both act on the leaf data in its ack cycle.

The bench provokes the clash with pages whose bits are already set, with read-only and supervisor pages, and with repeated reads and writes to one page. In each case a queue-based reference predicts the exact sequence of memory accesses and the final outcome. Every acknowledged access is compared against the head of that queue, and the number of accesses is checked once the result appears. A missing or extra write-back, or a write on a faulting walk, is therefore caught.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   // Bit positions inside a table entry
   localparam int unsigned BIT_V = 0;
   localparam int unsigned BIT_W = 1;
   localparam int unsigned BIT_U = 2;
   localparam int unsigned BIT_A = 3;
   localparam int unsigned BIT_D = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD1,
      ST_RD2,
      ST_WB,
      ST_DONE,
      ST_FAULT
   } walk_st_t;

   typedef enum logic [1:0] {
      CAUSE_NONE = 2'd0,
      CAUSE_L1   = 2'd1,
      CAUSE_L2   = 2'd2,
      CAUSE_PERM = 2'd3
   } cause_t;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int unsigned PA_W  = 32,
   parameter int unsigned IDX_W = 10
) (
   input  logic [PA_W-1:0]  tbl_base_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic [PA_W-1:0]  ent_addr_o
);
   localparam int unsigned OFF_W = IDX_W + 2;

   initial begin : elab_chk
      AST_IDX_FITS: assert (OFF_W <= PA_W) else $error("index wider than address");
   end

   logic [OFF_W-1:0] byte_off;
   assign byte_off   = {idx_i, 2'b00};
   assign ent_addr_o = tbl_base_i + PA_W'(byte_off);
endmodule

// File: rtl/ptw_leaf_check.sv
module ptw_leaf_check
   import ptw_pkg::*;
#(
   parameter int unsigned PTE_W      = 32,
   parameter bit          CHECK_USER = 1'b1
) (
   input  logic [PTE_W-1:0] pte_i,
   input  logic             is_write_i,
   input  logic             is_user_i,
   output logic             perm_ok_o,
   output logic [PTE_W-1:0] pte_upd_o,
   output logic             need_wb_o
);
   logic user_ok;

   generate
      if (CHECK_USER) begin : g_user
         assign user_ok = !is_user_i || pte_i[BIT_U];
      end else begin : g_nouser
         logic unused_user;
         assign unused_user = is_user_i;
         assign user_ok     = 1'b1;
      end
   endgenerate

   assign perm_ok_o = user_ok && (!is_write_i || pte_i[BIT_W]);

   always_comb begin
      pte_upd_o        = pte_i;
      pte_upd_o[BIT_A] = 1'b1;
      if (is_write_i) pte_upd_o[BIT_D] = 1'b1;
   end

   assign need_wb_o = (pte_upd_o != pte_i);
endmodule

// File: rtl/pt_walk_unit.sv
module pt_walk_unit
   import ptw_pkg::*;
#(
   parameter int unsigned VA_W       = 32,
   parameter int unsigned PA_W       = 32,
   parameter int unsigned IDX_W      = 10,
   parameter int unsigned OFS_W      = 12,
   parameter bit          CHECK_USER = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PA_W-1:0] ptbr_i,
   input  logic            req_valid_i,
   output logic            req_ready_o,
   input  logic [VA_W-1:0] req_vaddr_i,
   input  logic            req_write_i,
   input  logic            req_user_i,
   output logic            mem_req_o,
   output logic            mem_we_o,
   output logic [PA_W-1:0] mem_addr_o,
   output logic [PA_W-1:0] mem_wdata_o,
   input  logic            mem_ack_i,
   input  logic [PA_W-1:0] mem_rdata_i,
   output logic            rsp_done_o,
   output logic            rsp_fault_o,
   output logic [1:0]      rsp_cause_o,
   output logic [PA_W-1:0] rsp_paddr_o,
   input  logic            rsp_ack_i
);
   localparam int unsigned LEVELS  = 2;
   localparam int unsigned FRAME_W = PA_W - OFS_W;

   initial begin : elab_chk
      AST_VA_SPLIT: assert (VA_W == LEVELS*IDX_W + OFS_W) else $error("bad address split");
      AST_FLAGS_FIT: assert (OFS_W > BIT_D) else $error("flags overlap frame");
      AST_PA_WIDE: assert (PA_W > OFS_W) else $error("no frame bits");
   end

   walk_st_t           st_q;
   cause_t             cause_q;
   logic [VA_W-1:0]    vaddr_q;
   logic               wr_q;
   logic               usr_q;
   logic [PA_W-1:0]    base_q;
   logic [FRAME_W-1:0] l1_frame_q;
   logic [PA_W-1:0]    leaf_q;
   logic [PA_W-1:0]    paddr_q;

   // Entry address per table level
   logic [PA_W-1:0] lvl_base [LEVELS];
   logic [PA_W-1:0] lvl_addr [LEVELS];

   assign lvl_base[0] = base_q;
   assign lvl_base[1] = {l1_frame_q, {OFS_W{1'b0}}};

   for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
      ptw_addr_gen #(.PA_W(PA_W), .IDX_W(IDX_W)) u_agen (
         .tbl_base_i (lvl_base[g]),
         .idx_i      (vaddr_q[VA_W-1-g*IDX_W -: IDX_W]),
         .ent_addr_o (lvl_addr[g])
      );
   end

   // Rights check and used/dirty update on the returning leaf
   logic            perm_ok;
   logic [PA_W-1:0] leaf_upd;
   logic            need_wb;

   ptw_leaf_check #(.PTE_W(PA_W), .CHECK_USER(CHECK_USER)) u_leaf (
      .pte_i      (mem_rdata_i),
      .is_write_i (wr_q),
      .is_user_i  (usr_q),
      .perm_ok_o  (perm_ok),
      .pte_upd_o  (leaf_upd),
      .need_wb_o  (need_wb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         cause_q    <= CAUSE_NONE;
         vaddr_q    <= '0;
         wr_q       <= 1'b0;
         usr_q      <= 1'b0;
         base_q     <= '0;
         l1_frame_q <= '0;
         leaf_q     <= '0;
         paddr_q    <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid_i) begin
                  vaddr_q <= req_vaddr_i;
                  wr_q    <= req_write_i;
                  usr_q   <= req_user_i;
                  base_q  <= ptbr_i;
                  st_q    <= ST_RD1;
               end
            end
            ST_RD1: begin
               if (mem_ack_i) begin
                  l1_frame_q <= mem_rdata_i[PA_W-1:OFS_W];
                  if (!mem_rdata_i[BIT_V]) begin
                     cause_q <= CAUSE_L1;
                     st_q    <= ST_FAULT;
                  end else begin
                     st_q <= ST_RD2;
                  end
               end
            end
            ST_RD2: begin
               if (mem_ack_i) begin
                  if (!mem_rdata_i[BIT_V]) begin
                     cause_q <= CAUSE_L2;
                     st_q    <= ST_FAULT;
                  end else if (!perm_ok) begin
                     cause_q <= CAUSE_PERM;
                     st_q    <= ST_FAULT;
                  end else begin
                     cause_q <= CAUSE_NONE;
                     paddr_q <= {mem_rdata_i[PA_W-1:OFS_W], vaddr_q[OFS_W-1:0]};
                     leaf_q  <= leaf_upd;
                     st_q    <= need_wb ? ST_WB : ST_DONE;
                  end
               end
            end
            ST_WB: begin
               if (mem_ack_i) st_q <= ST_DONE;
            end
            ST_DONE, ST_FAULT: begin
               if (rsp_ack_i) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready_o = (st_q == ST_IDLE);
   assign mem_req_o   = (st_q == ST_RD1) || (st_q == ST_RD2) || (st_q == ST_WB);
   assign mem_we_o    = (st_q == ST_WB);
   assign mem_addr_o  = (st_q == ST_RD1) ? lvl_addr[0] : lvl_addr[1];
   assign mem_wdata_o = leaf_q;
   assign rsp_done_o  = (st_q == ST_DONE);
   assign rsp_fault_o = (st_q == ST_FAULT);
   assign rsp_cause_o = cause_q;
   assign rsp_paddr_o = paddr_q;

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)); // R10
   AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done_o && !rsp_ack_i |=> rsp_done_o && $stable(rsp_paddr_o)); // R8
   AST_FAULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault_o && !rsp_ack_i |=> rsp_fault_o && $stable(rsp_cause_o)); // R8
   AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done_o || rsp_fault_o) && rsp_ack_i |=> req_ready_o); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready_o |-> !mem_req_o && !rsp_done_o && !rsp_fault_o); // R9
   AST_WB_USED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && mem_we_o |-> mem_wdata_o[BIT_A] && mem_wdata_o[BIT_V]); // R6
   AST_PADDR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done_o |-> rsp_paddr_o[OFS_W-1:0] == vaddr_q[OFS_W-1:0]); // R3
   AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault_o |-> rsp_cause_o != 2'd0); // R4
endmodule

// File: tb/pt_walk_unit_test.sv
module pt_walk_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ptbr = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        rsp_done, rsp_fault;
   logic [1:0]  rsp_cause;
   logic [31:0] rsp_paddr;
   logic        rsp_ack = 1'b0;

   int checks = 0;
   int errors = 0;

   logic [31:0] mem [0:4095];

   always #2 clk = ~clk;

   pt_walk_unit uut (
      .clk(clk), .rst_n(rst_n), .ptbr_i(ptbr),
      .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
      .req_write_i(req_write), .req_user_i(req_user),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
      .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
      .rsp_done_o(rsp_done), .rsp_fault_o(rsp_fault), .rsp_cause_o(rsp_cause),
      .rsp_paddr_o(rsp_paddr), .rsp_ack_i(rsp_ack)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] pte(input logic [19:0] frame, input logic [4:0] flags);
      return {frame, 7'b0, flags};
   endfunction

   // Reference walk: expected access queue and outcome, then cycle-by-cycle compare
   task automatic walk(input logic [31:0] va, input bit wr, input bit usr, input logic [31:0] base,
                       input int lat, input bit noise, input int hold);
      logic [31:0] q_addr [$];
      bit          q_we   [$];
      logic [31:0] q_wd   [$];
      logic [31:0] e1, e2, upd, a1, a2, exp_pa;
      logic [31:0] held_pa;
      logic [1:0]  held_cause;
      int          cause = 0;
      int          served = 0;
      int          cnt = 0;
      int          cyc = 0;
      a1 = base + {20'b0, va[31:22], 2'b00};
      e1 = mem[a1[13:2]];
      q_addr.push_back(a1); q_we.push_back(1'b0); q_wd.push_back('0);
      exp_pa = '0;
      if (!e1[0]) cause = 1;
      else begin
         a2 = {e1[31:12], 12'h000} + {20'b0, va[21:12], 2'b00};
         e2 = mem[a2[13:2]];
         q_addr.push_back(a2); q_we.push_back(1'b0); q_wd.push_back('0);
         if (!e2[0]) cause = 2;
         else if ((wr && !e2[1]) || (usr && !e2[2])) cause = 3;
         else begin
            upd = e2 | 32'h8 | (wr ? 32'h10 : 32'h0);
            if (upd != e2) begin
               q_addr.push_back(a2); q_we.push_back(1'b1); q_wd.push_back(upd);
            end
            exp_pa = {e2[31:12], va[11:0]};
         end
      end
      @(negedge clk);
      chk(req_ready === 1'b1, "R9 ready before request", {31'b0, req_ready}, 32'h1);
      req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr; ptbr = base;
      forever begin
         @(negedge clk);
         mem_ack = 1'b0;
         cyc++;
         if (cyc == 1) req_valid = 1'b0;
         if (noise && cyc == 2) begin
            req_valid = 1'b1; req_vaddr = 32'hDEAD_B123; req_write = 1'b1; ptbr = 32'h0000_2000;
         end
         if (noise && cyc == 3) req_valid = 1'b0;
         if (rsp_done || rsp_fault || cyc > 200) break;
         chk(req_ready === 1'b0, "R9 busy not ready", {31'b0, req_ready}, 32'h0);
         if (mem_req) begin
            if (cnt == lat) begin
               cnt = 0;
               if (served < q_addr.size()) begin
                  chk(mem_addr === q_addr[served],
                      served == 0 ? "R1 level-one address" : served == 1 ? "R2 leaf address" : "R6 write-back address",
                      mem_addr, q_addr[served]);
                  chk(mem_we === q_we[served], "R7 access direction", {31'b0, mem_we}, {31'b0, q_we[served]});
                  if (q_we[served])
                     chk(mem_wdata === q_wd[served], "R6 updated leaf", mem_wdata, q_wd[served]);
               end else begin
                  chk(1'b0, "R7 unexpected extra access", mem_addr, '0);
               end
               if (mem_we) mem[mem_addr[13:2]] = mem_wdata;
               else mem_rdata = mem[mem_addr[13:2]];
               mem_ack = 1'b1;
               served++;
            end else cnt++;
         end
      end
      chk(cyc <= 200, "R8 walk finishes", cyc, 200);
      chk(served == q_addr.size(), cause == 0 ? "R7 access count" : (cause == 3 ? "R5 no write on fault" : "R4 access count"),
          served, q_addr.size());
      chk(rsp_done === (cause == 0) && rsp_fault === (cause != 0), "R8 single outcome",
          {30'b0, rsp_done, rsp_fault}, {30'b0, cause == 0, cause != 0});
      chk(rsp_cause === 2'(cause), cause == 3 ? "R5 cause" : cause == 0 ? "R3 cause none" : "R4 cause",
          {30'b0, rsp_cause}, cause);
      if (cause == 0) chk(rsp_paddr === exp_pa, "R3 physical address", rsp_paddr, exp_pa);
      held_pa = rsp_paddr; held_cause = rsp_cause;
      for (int h = 0; h < hold; h++) begin
         @(negedge clk);
         chk((rsp_done || rsp_fault) && rsp_paddr === held_pa && rsp_cause === held_cause,
             "R8 result held", rsp_paddr, held_pa);
      end
      rsp_ack = 1'b1;
      @(negedge clk);
      rsp_ack = 1'b0;
      chk(req_ready === 1'b1 && !rsp_done && !rsp_fault, "R8 idle after ack",
          {29'b0, req_ready, rsp_done, rsp_fault}, 32'h4);
      ptbr = base;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      for (int i = 0; i < 4096; i++) mem[i] = '0;
      // Level-one table at 0x0000
      mem[12'h000] = pte(20'h00001, 5'b00001);
      mem[12'h3FF] = pte(20'h00002, 5'b00001);
      // Leaf table at 0x1000
      mem[12'h400] = pte(20'h12345, 5'b00111);   // user, writable
      mem[12'h401] = pte(20'h00ABC, 5'b00101);   // user, read-only
      mem[12'h402] = pte(20'h00777, 5'b00011);   // supervisor, writable
      mem[12'h403] = '0;                         // invalid
      // Leaf table at 0x2000
      mem[12'h800] = pte(20'h55555, 5'b00101);
      mem[12'hBFF] = pte(20'hFFFFF, 5'b11111);   // used and dirty already
      // Second level-one table at 0x3000
      mem[12'hC00] = pte(20'h00002, 5'b00001);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b1 && !mem_req && !rsp_done && !rsp_fault, "R9 reset state",
          {28'b0, req_ready, mem_req, rsp_done, rsp_fault}, 32'h8);

      walk(32'h0000_0ABC, 1'b0, 1'b1, 32'h0, 0, 1'b0, 0);   // R6 used set
      walk(32'h0000_0ABC, 1'b0, 1'b1, 32'h0, 2, 1'b0, 3);   // R7 no write-back
      walk(32'h0000_0123, 1'b1, 1'b1, 32'h0, 1, 1'b0, 1);   // R6 dirty set
      walk(32'h0000_0123, 1'b1, 1'b1, 32'h0, 0, 1'b0, 0);   // R7 no write-back
      walk(32'h0000_1004, 1'b1, 1'b1, 32'h0, 1, 1'b0, 2);   // R5 read-only
      walk(32'h0000_1004, 1'b0, 1'b1, 32'h0, 0, 1'b0, 0);   // R3 read ok
      walk(32'h0000_2010, 1'b0, 1'b1, 32'h0, 0, 1'b0, 0);   // R5 supervisor page
      walk(32'h0000_2010, 1'b1, 1'b0, 32'h0, 3, 1'b0, 0);   // R6 used+dirty
      walk(32'h0000_3000, 1'b0, 1'b0, 32'h0, 1, 1'b0, 2);   // R4 leaf invalid
      walk(32'h0140_0000, 1'b0, 1'b0, 32'h0, 2, 1'b0, 2);   // R4 level-one invalid
      walk(32'hFFFF_FFFF, 1'b1, 1'b1, 32'h0, 0, 1'b0, 0);   // R3 top corner, R7
      walk(32'h0000_0777, 1'b0, 1'b1, 32'h3000, 1, 1'b0, 0); // R1 other base
      walk(32'h0000_0ABC, 1'b1, 1'b1, 32'h0, 2, 1'b1, 1);   // R9 noise while busy

      chk(mem[12'h400] === pte(20'h12345, 5'b11111), "R6 leaf in memory", mem[12'h400], pte(20'h12345, 5'b11111));
      chk(mem[12'h401] === pte(20'h00ABC, 5'b01101), "R5 read-only leaf not dirtied", mem[12'h401], pte(20'h00ABC, 5'b01101));

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule